// File: doc/BRIEF.md
# Analog Test Column Stripe Selector

This block picks which group of adjacent matrix columns is routed to the analog test outputs of a column-parallel pixel sensor. It always selects exactly eight adjacent columns, the same number as there are analog output pads. It presents the selection in two forms: the index of the first selected column, and a per-column enable bus that drives the analog multiplexers.

Two modes exist. In scan mode the selection starts at the left edge of the array. It moves one eight-column stripe to the right each time the row sequencer reports a finished frame, so every stripe is read over all rows before the next one is taken. After the rightmost stripe it wraps back to the left edge. In fixed mode a window of eight columns at the centre of the array stays connected. This mode is meant for readout at the nominal clock rate. Scan mode is meant for a slower clock, and a rate output tells the clock logic which rate applies.

A requested mode change waits for the next frame boundary, so a frame is never split between two selections. Dropping enable turns every column off and freezes the block.

Top module: `col_stripe_sel`

## Requirements
- R1: After reset the block is in scan mode with the window starting at column 0, `fast_rate` is 0 and `scan_wrap` is 0.
- R2: While `enable` is 1, exactly the eight bits `col_en[base .. base+7]` are 1, where base is the value on `stripe_base`. All other bits of `col_en` are 0.
- R3: In scan mode, a cycle with `frame_done` and `enable` both 1 moves `stripe_base` up by 8 from the following cycle on.
- R4: In cycles without an accepted frame boundary, `stripe_base` does not change.
- R5: An accepted frame boundary while the window starts at column 952 (the last stripe) returns `stripe_base` to 0. It also sets `scan_wrap` to 1 for exactly one cycle. `scan_wrap` is 0 at all other times.
- R6: In fixed mode, `stripe_base` is 476, so columns 476 to 483 are selected, and this holds for any number of frames.
- R7: A new level on `mode_fixed` (1 means fixed, 0 means scan) takes effect only at the next accepted frame boundary. `fast_rate` is 1 exactly when fixed mode is active.
- R8: A mode change takes effect at an accepted frame boundary and returns the scan position to stripe 0. A later return to scan mode therefore starts at column 0.
- R9: While `enable` is 0, every bit of `col_en` is 0, and `frame_done` has no effect on the scan position or on the active mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 drives the selected columns; 0 turns all columns off and freezes the state |
| mode_fixed | input | 1 | Requested mode: 1 fixed centre window, 0 stripe scan |
| frame_done | input | 1 | One-cycle pulse marking the end of a full frame |
| stripe_base | output | 10 | Index of the first selected column |
| col_en | output | 960 | Per-column analog routing enable |
| fast_rate | output | 1 | 1 while fixed mode (nominal clock) is active |
| scan_wrap | output | 1 | One-cycle pulse when the scan returns to the left edge |

## Verification
The state hardest to reach from the ports is the wrap from the last stripe. It only happens after 119 accepted frame boundaries in an unbroken run of scan mode. The bench sends back-to-back frame pulses from a freshly restarted scan, checks that the window stands at column 952, and then sends one more pulse to see the return to zero together with the single-cycle flag. The deferred mode switch is also checked. The bench changes `mode_fixed` between pulses, and confirms that the outputs stay unchanged until the pulse arrives, and also while `enable` is low.

// File: rtl/stsel_pkg.sv
package stsel_pkg;

  // First column of stripe number idx
  function automatic int stripe_first_col(input int idx, input int width);
    return idx * width;
  endfunction

  // Column col lies inside the window that starts at base
  function automatic logic col_in_window(input int col, input int base, input int width);
    return (col >= base) && (col < base + width);
  endfunction

  // Left edge of a centred window
  function automatic int centre_first_col(input int cols, input int width);
    return cols / 2 - width / 2;
  endfunction

endpackage

// File: rtl/stsel_scan_ctr.sv
module stsel_scan_ctr #(
  parameter int NUM_STRIPES = 120,
  localparam int IDX_W = $clog2(NUM_STRIPES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [IDX_W-1:0] idx,
  output logic             wrap_pulse
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STRIPES - 1);

  logic at_last;
  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= step && at_last;
      if (clear)
        idx <= '0;
      else if (step)
        idx <= at_last ? '0 : idx + 1'b1;
    end
  end

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !at_last) |=> idx == $past(idx) + 1'b1);
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && at_last) |=> (idx == '0) && wrap_pulse);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(idx));
  // R5
  wrap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

endmodule

// File: rtl/stsel_mode_trk.sv
module stsel_mode_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic req_fixed,
  output logic fixed_act,
  output logic switch_evt
);
  assign switch_evt = boundary && (req_fixed != fixed_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fixed_act <= 1'b0;
    else if (switch_evt)
      fixed_act <= req_fixed;
  end

  // R7
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(fixed_act));

endmodule

// File: rtl/stsel_col_dec.sv
module stsel_col_dec
  import stsel_pkg::*;
#(
  parameter int NUM_COLS = 960,
  parameter int WIN      = 8,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [COL_W-1:0]    base,
  output logic [NUM_COLS-1:0] col_en
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_en[c] = enable && col_in_window(c, int'(base), WIN);
  end

  // R2
  win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> $countones(col_en) == WIN);
  // R9
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> col_en == '0);

endmodule

// File: rtl/col_stripe_sel.sv
module col_stripe_sel
  import stsel_pkg::*;
#(
  parameter int NUM_COLS = 960,
  parameter int STRIPE_W = 8,
  localparam int NUM_STRIPES = NUM_COLS / STRIPE_W,
  localparam int IDX_W       = $clog2(NUM_STRIPES),
  localparam int COL_W       = $clog2(NUM_COLS),
  localparam int CENTRE_COL  = centre_first_col(NUM_COLS, STRIPE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                mode_fixed,
  input  logic                frame_done,
  output logic [COL_W-1:0]    stripe_base,
  output logic [NUM_COLS-1:0] col_en,
  output logic                fast_rate,
  output logic                scan_wrap
);
  logic             boundary;
  logic             fixed_act;
  logic             switch_evt;
  logic             scan_step;
  logic [IDX_W-1:0] scan_idx;

  assign boundary  = frame_done && enable;
  assign scan_step = boundary && !fixed_act && !switch_evt;

  stsel_mode_trk u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .req_fixed  (mode_fixed),
    .fixed_act  (fixed_act),
    .switch_evt (switch_evt)
  );

  stsel_scan_ctr #(.NUM_STRIPES(NUM_STRIPES)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (scan_step),
    .clear      (switch_evt),
    .idx        (scan_idx),
    .wrap_pulse (scan_wrap)
  );

  assign stripe_base = fixed_act ? COL_W'(CENTRE_COL)
                                 : COL_W'(stripe_first_col(int'(scan_idx), STRIPE_W));
  assign fast_rate   = fixed_act;

  stsel_col_dec #(.NUM_COLS(NUM_COLS), .WIN(STRIPE_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .base   (stripe_base),
    .col_en (col_en)
  );

  // R6
  centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rate |-> stripe_base == COL_W'(CENTRE_COL));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> scan_idx == '0);
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(stripe_base) && $stable(fast_rate));
  // R5
  no_wrap_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fixed_act) |-> !scan_wrap);

endmodule

// File: tb/tb_col_stripe_sel.sv
module tb_col_stripe_sel;
  localparam int NC = 960;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          mode_fixed = 1'b0;
  logic          frame_done = 1'b0;
  logic [9:0]    stripe_base;
  logic [NC-1:0] col_en;
  logic          fast_rate;
  logic          scan_wrap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  col_stripe_sel dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_fixed(mode_fixed),
    .frame_done(frame_done), .stripe_base(stripe_base), .col_en(col_en),
    .fast_rate(fast_rate), .scan_wrap(scan_wrap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_base(input string req, input int exp);
    chk(int'(stripe_base) == exp, req, int'(stripe_base), exp);
  endtask

  // Count bits of col_en that differ from the expected window
  task automatic chk_cols(input string req, input int base, input bit on);
    int bad = 0;
    for (int c = 0; c < NC; c++) begin
      bit want = on && (c >= base) && (c < base + SW);
      if (col_en[c] !== want) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_done = 1'b1;
    @(negedge clk) frame_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; enable = 1'b1; mode_fixed = 1'b0; frame_done = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_base("R1 base", 0);
    chk(fast_rate == 1'b0, "R1 fast_rate", fast_rate, 0);
    chk(scan_wrap == 1'b0, "R1 scan_wrap", scan_wrap, 0);
    chk_cols("R2 window at reset", 0, 1'b1);
  endtask

  task automatic t_scan_steps();
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      pulse_frame();
      chk_base("R3 step", i * SW);
      repeat (3) @(negedge clk);
      chk_base("R4 hold between frames", i * SW);
    end
    chk_cols("R2 window at stripe 5", 5 * SW, 1'b1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 119; i++) pulse_frame();
    chk_base("R5 last stripe", 952);
    chk(scan_wrap == 1'b0, "R5 no early wrap", scan_wrap, 0);
    chk_cols("R2 window at last stripe", 952, 1'b1);
    pulse_frame();
    chk_base("R5 wrap to zero", 0);
    chk(scan_wrap == 1'b1, "R5 wrap flag", scan_wrap, 1);
    @(negedge clk);
    chk(scan_wrap == 1'b0, "R5 flag one cycle", scan_wrap, 0);
  endtask

  task automatic t_fixed_and_return();
    do_reset();
    pulse_frame(); pulse_frame(); pulse_frame();
    chk_base("R3 before switch", 24);
    @(negedge clk) mode_fixed = 1'b1;
    repeat (2) @(negedge clk);
    chk_base("R7 request deferred", 24);
    chk(fast_rate == 1'b0, "R7 rate deferred", fast_rate, 0);
    pulse_frame();
    chk_base("R6 centre", 476);
    chk(fast_rate == 1'b1, "R7 rate fixed", fast_rate, 1);
    chk_cols("R6 centre columns", 476, 1'b1);
    for (int i = 0; i < 4; i++) pulse_frame();
    chk_base("R6 centre stays", 476);
    chk(scan_wrap == 1'b0, "R5 no flag in fixed", scan_wrap, 0);
    @(negedge clk) mode_fixed = 1'b0;
    @(negedge clk);
    chk_base("R7 return deferred", 476);
    pulse_frame();
    chk_base("R8 scan restarts", 0);
    chk(fast_rate == 1'b0, "R7 rate scan", fast_rate, 0);
  endtask

  task automatic t_disable();
    do_reset();
    pulse_frame(); pulse_frame();
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk_cols("R9 all off", 0, 1'b0);
    pulse_frame(); pulse_frame();
    mode_fixed = 1'b1;
    pulse_frame();
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    chk_base("R9 index held", 16);
    chk(fast_rate == 1'b0, "R9 mode held", fast_rate, 0);
    chk_cols("R2 window after enable", 16, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_scan_steps();
    t_wrap();
    t_fixed_and_return();
    t_disable();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule